// File: doc/BRIEF.md
# Waveform playback and snapshot capture

This block moves complex baseband samples for a transceiver loopback test. On the transmit side a host fills a waveform memory through a plain write port. It sets a length in I/Q pairs and issues a play command. The block then streams the memory toward the DAC interface one word per clock. It loops over the programmed length without end, and leaves no idle cycle at the wrap.

On the receive side the host asks for a snapshot of a given number of pairs. The block waits for the next I sample on the ADC stream and stores the requested pairs back to back into a capture buffer. It then raises a done flag, and the host reads the buffer through a registered read port. A snapshot may only begin while playback runs, so the captured data contains the signal the block is sending. A request made while transmission is stopped only raises a sticky error flag.

Samples are 14-bit values held left-aligned in 16-bit words. I and Q words are interleaved, with I on even word addresses and Q on odd ones.

Top module: `wave_loop_capture`

## Requirements
- R1: While `tx_active` is high, the DAC port presents one memory word per cycle in ascending word-address order with `dac_valid` high. The first word (address 0) appears one cycle after `tx_active` rises. `dac_is_q` is 0 for even word addresses (I) and 1 for odd ones (Q).
- R2: The length register counts I/Q pairs and resets to 1. After word 2*len-1 the stream continues with word 0 on the very next cycle. A length write of 0 leaves the register unchanged, and a length above the memory depth in pairs is clamped to that depth.
- R3: A play command starts playback from word 0 when playback is stopped. While playback is running it has no effect, and the stream continues without restarting.
- R4: A waveform memory write or a length write stops playback. `tx_active` and `dac_valid` are low from the following cycle onward, and only a new play command restarts it.
- R5: A snapshot request made while no capture is in progress and playback is stopped sets `snap_err`, which then stays high until reset. `snap_done`, `snap_busy` and the buffer contents stay unchanged.
- R6: An accepted request clears `snap_done` and raises `snap_busy`. The block takes the first ADC sample with `adc_is_q`=0 that is presented in the cycle after the request. It stores 2*len consecutive ADC words at buffer addresses 0 upward, then drops `snap_busy` and raises `snap_done`.
- R7: Every stored word holds ADC bits 15..2 unchanged and has bits 1..0 forced to zero.
- R8: A requested snapshot length of 0, or one above the buffer depth in pairs, captures the full buffer depth.
- R9: A snapshot request while a capture is in progress is ignored, and the running capture completes with its original length.
- R10: `snap_rdata` returns the buffer word at `snap_raddr` one cycle after the address is presented.
- R11: After reset, `tx_active`, `dac_valid`, `snap_busy`, `snap_done` and `snap_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfm_we | input | 1 | Waveform memory write strobe |
| wfm_waddr | input | $clog2(2*WFM_PAIRS) | Waveform word address (even = I, odd = Q) |
| wfm_wdata | input | 16 | Waveform word |
| wfm_len_we | input | 1 | Length register write strobe |
| wfm_len | input | $clog2(WFM_PAIRS+1) | Playback length in I/Q pairs |
| play_start | input | 1 | Play command pulse |
| tx_active | output | 1 | Playback running |
| dac_valid | output | 1 | DAC word valid |
| dac_is_q | output | 1 | DAC word is a Q sample |
| dac_data | output | 16 | DAC word |
| adc_data | input | 16 | ADC sample word |
| adc_is_q | input | 1 | ADC word is a Q sample |
| snap_req | input | 1 | Snapshot request pulse |
| snap_len | input | $clog2(CAP_PAIRS+1) | Snapshot length in I/Q pairs |
| snap_busy | output | 1 | Capture in progress |
| snap_done | output | 1 | Last capture complete |
| snap_err | output | 1 | Sticky: request made while playback stopped |
| snap_raddr | input | $clog2(2*CAP_PAIRS) | Capture buffer read word address |
| snap_rdata | output | 16 | Capture buffer read word |

## Verification
The bench builds the block with a 16-pair waveform memory and an 8-pair capture buffer. At these sizes a length write above the depth lands the wrap at the very top of memory, and a zero or oversize snapshot request fills the whole buffer. Both limits are checked in a few dozen cycles. The ADC stimulus has non-zero low bits and alternates I and Q continuously, so the I-alignment of the first captured word and the zeroing of the two low bits are both exercised on every snapshot.

// File: rtl/wlc_pkg.sv
// Package: shared sample type and capture state encoding.
package wlc_pkg;
    localparam int SAMPLE_W = 16;
    typedef logic [SAMPLE_W-1:0] word_t;
    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_ARM  = 2'd1,
        CAP_RUN  = 2'd2
    } cap_state_t;
endpackage

// File: rtl/wlc_sample_ram.sv
// Simple dual-port sample RAM: one synchronous write port and one
// registered read port. Assumes no reset of contents is required.
module wlc_sample_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store a word on the write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read, one cycle latency.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/wlc_player.sv
// Waveform player: holds the transmit memory and the pair-count length,
// and loops the memory toward the DAC with no gap at the wrap.
// Assumes the host never writes while expecting playback to continue:
// any write stops playback.
module wlc_player
    import wlc_pkg::*;
#(
    parameter int W_PAIRS = 512,
    localparam int WORDS  = 2 * W_PAIRS,
    localparam int AW     = $clog2(WORDS),
    localparam int LW     = $clog2(W_PAIRS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic          len_we,
    input  logic [LW-1:0] len_in,
    input  logic          play,
    output logic          playing,
    output logic          dac_valid,
    output logic          dac_is_q,
    output word_t         dac_data
);
    logic [LW-1:0] len_q;
    logic [AW-1:0] ptr_q;
    logic          play_q;
    logic          vld_q;
    logic          isq_q;
    logic          stop;
    logic [LW:0]   last_w;
    logic          at_end;

    assign stop   = wr_en | len_we;
    assign last_w = {len_q, 1'b0} - (LW+1)'(1);
    assign at_end = ((LW+1)'(ptr_q) == last_w);

    // Length register in pairs: zero ignored, oversize clamped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= LW'(1);
        end else if (len_we && len_in != '0) begin
            len_q <= (len_in > LW'(W_PAIRS)) ? LW'(W_PAIRS) : len_in;
        end
    end

    // Playback run flag: host writes stop it, play starts it from idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          play_q <= 1'b0;
        else if (stop)       play_q <= 1'b0;
        else if (play)       play_q <= 1'b1;
    end

    // Word pointer: held at 0 while idle, wraps after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n || stop || !play_q) ptr_q <= '0;
        else if (at_end)               ptr_q <= '0;
        else                           ptr_q <= ptr_q + AW'(1);
    end

    // DAC side qualifiers aligned with the registered RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            isq_q <= 1'b0;
        end else begin
            vld_q <= play_q & ~stop;
            isq_q <= ptr_q[0];
        end
    end

    wlc_sample_ram #(.DEPTH(WORDS), .W(SAMPLE_W)) u_wfm_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ptr_q),
        .rdata (dac_data)
    );

    assign playing   = play_q;
    assign dac_valid = vld_q;
    assign dac_is_q  = isq_q;

    // R2: after the last word the pointer returns to word 0.
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (play_q && !stop && at_end) |=> (ptr_q == '0));

    // R4: any host write leaves playback and the DAC stream off.
    a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!play_q && !vld_q));

    // R1: an I word is followed by a Q word or by the end of the stream.
    a_r1_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !isq_q) |=> (!vld_q || isq_q));

    // R3: playback always begins at word 0.
    a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(play_q) |-> (ptr_q == '0));
endmodule

// File: rtl/wlc_capture.sv
// Snapshot capture: on an accepted request, waits for an I sample and
// stores the requested number of pairs with the two low bits cleared.
// Assumes the ADC delivers one word per clock, alternating I and Q.
module wlc_capture
    import wlc_pkg::*;
#(
    parameter int C_PAIRS = 512,
    localparam int WORDS  = 2 * C_PAIRS,
    localparam int AW     = $clog2(WORDS),
    localparam int LW     = $clog2(C_PAIRS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [LW-1:0] req_len,
    input  logic          tx_on,
    input  word_t         adc_data,
    input  logic          adc_is_q,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data,
    output logic          busy,
    output logic          done,
    output logic          err
);
    cap_state_t    st_q;
    logic [AW-1:0] wptr_q;
    logic [LW:0]   last_q;
    logic [LW-1:0] len_eff;
    logic          we;
    word_t         wdata;
    logic          at_last;

    assign len_eff = (req_len == '0 || req_len > LW'(C_PAIRS)) ? LW'(C_PAIRS) : req_len;
    assign at_last = ((LW+1)'(wptr_q) == last_q);
    assign we      = (st_q == CAP_RUN) || (st_q == CAP_ARM && !adc_is_q);
    assign wdata   = {adc_data[SAMPLE_W-1:2], 2'b00};

    // Capture sequencer: accept, align to I, store, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CAP_IDLE;
            wptr_q <= '0;
            last_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            case (st_q)
                CAP_IDLE: begin
                    if (req && tx_on) begin
                        st_q   <= CAP_ARM;
                        done   <= 1'b0;
                        wptr_q <= '0;
                        last_q <= {len_eff, 1'b0} - (LW+1)'(1);
                    end else if (req) begin
                        err <= 1'b1;
                    end
                end
                CAP_ARM: begin
                    if (!adc_is_q) begin
                        st_q   <= CAP_RUN;
                        wptr_q <= AW'(1);
                    end
                end
                CAP_RUN: begin
                    if (at_last) begin
                        st_q   <= CAP_IDLE;
                        done   <= 1'b1;
                        wptr_q <= '0;
                    end else begin
                        wptr_q <= wptr_q + AW'(1);
                    end
                end
                default: st_q <= CAP_IDLE;
            endcase
        end
    end

    wlc_sample_ram #(.DEPTH(WORDS), .W(SAMPLE_W)) u_cap_ram (
        .clk   (clk),
        .we    (we),
        .waddr (wptr_q),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign busy = (st_q != CAP_IDLE);

    // R5: a request with playback stopped flags an error and stays idle.
    a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (req && st_q == CAP_IDLE && !tx_on) |=> (err && st_q == CAP_IDLE));

    // R6: done and busy are never high together.
    a_r6_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R6: stores land on consecutive addresses until the last one.
    a_r6_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAP_RUN && !at_last) |=> (wptr_q == $past(wptr_q) + AW'(1)));

    // R9: a request during a run does not end or restart it.
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CAP_RUN && req && !at_last) |=> (st_q == CAP_RUN));
endmodule

// File: rtl/wave_loop_capture.sv
// Top: waveform player and snapshot capture, with capture interlocked
// to the playback run flag. Assumes host and converter share one clock.
module wave_loop_capture
    import wlc_pkg::*;
#(
    parameter int WFM_PAIRS = 512,
    parameter int CAP_PAIRS = 512,
    localparam int WAW = $clog2(2 * WFM_PAIRS),
    localparam int WLW = $clog2(WFM_PAIRS + 1),
    localparam int CAW = $clog2(2 * CAP_PAIRS),
    localparam int CLW = $clog2(CAP_PAIRS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wfm_we,
    input  logic [WAW-1:0] wfm_waddr,
    input  logic [15:0]    wfm_wdata,
    input  logic           wfm_len_we,
    input  logic [WLW-1:0] wfm_len,
    input  logic           play_start,
    output logic           tx_active,
    output logic           dac_valid,
    output logic           dac_is_q,
    output logic [15:0]    dac_data,
    input  logic [15:0]    adc_data,
    input  logic           adc_is_q,
    input  logic           snap_req,
    input  logic [CLW-1:0] snap_len,
    output logic           snap_busy,
    output logic           snap_done,
    output logic           snap_err,
    input  logic [CAW-1:0] snap_raddr,
    output logic [15:0]    snap_rdata
);
    logic playing;

    wlc_player #(.W_PAIRS(WFM_PAIRS)) u_player (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wfm_we),
        .wr_addr   (wfm_waddr),
        .wr_data   (wfm_wdata),
        .len_we    (wfm_len_we),
        .len_in    (wfm_len),
        .play      (play_start),
        .playing   (playing),
        .dac_valid (dac_valid),
        .dac_is_q  (dac_is_q),
        .dac_data  (dac_data)
    );

    wlc_capture #(.C_PAIRS(CAP_PAIRS)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (snap_req),
        .req_len  (snap_len),
        .tx_on    (playing),
        .adc_data (adc_data),
        .adc_is_q (adc_is_q),
        .rd_addr  (snap_raddr),
        .rd_data  (snap_rdata),
        .busy     (snap_busy),
        .done     (snap_done),
        .err      (snap_err)
    );

    assign tx_active = playing;

    // R11: status outputs are low in the first cycle after reset.
    a_r11_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_active && !dac_valid && !snap_busy && !snap_done && !snap_err));
endmodule

// File: tb/test_wave_loop_capture.sv
module test_wave_loop_capture;
    localparam int WP  = 16;
    localparam int CP  = 8;
    localparam int WAW = $clog2(2*WP);
    localparam int WLW = $clog2(WP+1);
    localparam int CAW = $clog2(2*CP);
    localparam int CLW = $clog2(CP+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfm_we = 1'b0;
    logic [WAW-1:0] wfm_waddr = '0;
    logic [15:0] wfm_wdata = '0;
    logic wfm_len_we = 1'b0;
    logic [WLW-1:0] wfm_len = '0;
    logic play_start = 1'b0;
    logic tx_active, dac_valid, dac_is_q;
    logic [15:0] dac_data;
    logic [15:0] adc_data = '0;
    logic adc_is_q = 1'b0;
    logic snap_req = 1'b0;
    logic [CLW-1:0] snap_len = '0;
    logic snap_busy, snap_done, snap_err;
    logic [CAW-1:0] snap_raddr = '0;
    logic [15:0] snap_rdata;

    int n_checks = 0;
    int n_fail = 0;
    int an = 0;
    logic [15:0] mw [2*WP];
    logic [15:0] cap_exp [2*CP];

    wave_loop_capture #(.WFM_PAIRS(WP), .CAP_PAIRS(CP)) i_wave_loop_capture (
        .clk(clk), .rst_n(rst_n),
        .wfm_we(wfm_we), .wfm_waddr(wfm_waddr), .wfm_wdata(wfm_wdata),
        .wfm_len_we(wfm_len_we), .wfm_len(wfm_len), .play_start(play_start),
        .tx_active(tx_active), .dac_valid(dac_valid), .dac_is_q(dac_is_q), .dac_data(dac_data),
        .adc_data(adc_data), .adc_is_q(adc_is_q),
        .snap_req(snap_req), .snap_len(snap_len),
        .snap_busy(snap_busy), .snap_done(snap_done), .snap_err(snap_err),
        .snap_raddr(snap_raddr), .snap_rdata(snap_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] adcf(input int n);
        return 16'h3C5B ^ 16'(n * 16'h0923);
    endfunction

    // ADC source: one word per cycle, I on even sample numbers.
    always @(negedge clk) begin
        an = an + 1;
        adc_data = adcf(an);
        adc_is_q = an[0];
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({tx_active, dac_valid, snap_busy, snap_done, snap_err} == 5'b0, "R11",
              {27'b0, tx_active, dac_valid, snap_busy, snap_done, snap_err}, 0);
    endtask

    task automatic t_load();
        for (int k = 0; k < 2*WP; k++) begin
            mw[k] = 16'(16'h0203 + k * 16'h0111);
            @(negedge clk);
            wfm_we = 1'b1; wfm_waddr = WAW'(k); wfm_wdata = mw[k];
        end
        @(negedge clk);
        wfm_we = 1'b0;
    endtask

    task automatic t_set_len(input int l);
        @(negedge clk);
        wfm_len_we = 1'b1; wfm_len = WLW'(l);
        @(negedge clk);
        wfm_len_we = 1'b0;
    endtask

    // Follow n stream words starting at index k0; pulse play after check pulse_at.
    task automatic t_follow(input int l, input int k0, input int n, input int pulse_at);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            play_start = 1'b0;
            begin
                int k = (k0 + i) % (2*l);
                check(dac_valid && dac_data == mw[k] && dac_is_q == k[0],
                      (k == 0 && i > 0) ? "R2 wrap" : "R1 stream",
                      {15'b0, dac_valid, dac_data}, {16'h1, mw[k]});
            end
            if (i == pulse_at) play_start = 1'b1;
        end
        @(negedge clk);
        play_start = 1'b0;
    endtask

    task automatic t_play(input int l, input int n, input int pulse_at);
        @(negedge clk);
        play_start = 1'b1;
        @(negedge clk);
        play_start = 1'b0;
        check(tx_active && !dac_valid, "R3 start", {30'b0, tx_active, dac_valid}, 32'h2);
        // pulse during follow is checked by R3: stream continues unbroken
        t_follow(l, 0, n, pulse_at);
    endtask

    task automatic t_stop_len(input int l);
        @(negedge clk);
        wfm_len_we = 1'b1; wfm_len = WLW'(l);
        @(negedge clk);
        wfm_len_we = 1'b0;
        check(!tx_active && !dac_valid, "R4 len stop", {30'b0, tx_active, dac_valid}, 0);
        repeat (3) @(negedge clk);
        check(!tx_active && !dac_valid, "R4 stays stopped", {30'b0, tx_active, dac_valid}, 0);
    endtask

    task automatic t_stop_mem();
        @(negedge clk);
        mw[2*WP-1] = 16'hBEEF;
        wfm_we = 1'b1; wfm_waddr = WAW'(2*WP-1); wfm_wdata = 16'hBEEF;
        @(negedge clk);
        wfm_we = 1'b0;
        check(!tx_active && !dac_valid, "R4 mem stop", {30'b0, tx_active, dac_valid}, 0);
    endtask

    // Issue a capture request; the expected words follow the first I sample
    // presented in the cycle after the request.
    task automatic t_capture(input int req_len, input int words, input bit extra_req);
        int n0, first;
        @(negedge clk);
        snap_req = 1'b1; snap_len = CLW'(req_len);
        @(negedge clk);
        #1;
        snap_req = 1'b0;
        n0 = an;
        first = (n0 % 2 == 0) ? n0 : n0 + 1;
        for (int k = 0; k < words; k++) cap_exp[k] = adcf(first + k) & 16'hFFFC;
        check(snap_busy && !snap_done, "R6 accept", {30'b0, snap_busy, snap_done}, 32'h2);
        if (extra_req) begin
            snap_req = 1'b1; snap_len = CLW'(1);   // R9: ignored while busy
            @(negedge clk);
            #1;
            snap_req = 1'b0;
        end
        for (int t = 0; t < 100 && !snap_done; t++) @(negedge clk);
        #1;
        check(snap_done && !snap_busy, "R6 done", {30'b0, snap_busy, snap_done}, 32'h1);
    endtask

    task automatic t_readback(input int words, input string rq);
        for (int a = 0; a < words; a++) begin
            @(negedge clk);
            snap_raddr = CAW'(a);
            @(negedge clk);
            check(snap_rdata == cap_exp[a] && snap_rdata[1:0] == 2'b00, rq, {16'b0, snap_rdata}, {16'b0, cap_exp[a]});
        end
    endtask

    task automatic t_reject();
        @(negedge clk);
        snap_req = 1'b1; snap_len = CLW'(2);
        @(negedge clk);
        snap_req = 1'b0;
        check(snap_err && snap_done && !snap_busy, "R5 reject",
              {29'b0, snap_err, snap_done, snap_busy}, 32'h6);
        repeat (4) @(negedge clk);
        check(snap_err, "R5 sticky", {31'b0, snap_err}, 1);
        snap_raddr = '0;
        @(negedge clk);
        check(snap_rdata == cap_exp[0], "R5 buffer kept", {16'b0, snap_rdata}, {16'b0, cap_exp[0]});
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();                       // R11
        t_load();
        t_set_len(3);
        t_play(3, 20, 7);                // R1, R2 wrap, R3 play ignored while running
        t_stop_len(0);                   // R4; zero length ignored (R2)
        t_play(3, 14, -1);               // R2: still 3 pairs
        t_capture(2, 4, 1'b0);           // R6, R7
        t_readback(4, "R10 R7 readback");
        t_capture(0, 2*CP, 1'b1);        // R8 zero means full, R9 extra request ignored
        t_readback(2*CP, "R8 R9 full capture");
        t_capture(15, 2*CP, 1'b0);       // R8 oversize clamp
        t_readback(2*CP, "R8 clamp capture");
        t_stop_mem();                    // R4
        t_reject();                      // R5
        t_set_len(31);                   // R2 clamp to WP pairs
        t_play(WP, 40, -1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule